// File: doc/BRIEF.md
# PWM Event Trigger Router

This block sits beside a PWM time-base and decides which of its comparison events reach which consumer. Three compare-match pulses (A, B, C) and an end-of-cycle pulse arrive one clock wide. A 16-bit control word, written and read over a simple register port, sets three things. The first is which compare events feed an ADC trigger, and how far that stream is divided down. The second is which event is forwarded as the generator trigger output. The third is which register write, if any, raises the update request on its own.

The ADC trigger path works in two steps. It first merges the enabled compare events into one event per clock. It then counts those events in a postscaler and emits a single-clock pulse on every (N+1)-th event. The update request is a sticky flag. It is raised by a software strobe, or by a write strobe of the selected register. It stays high until the clear input reports that the update has been taken at a period boundary. Every pin is plain control or status, with one pulse or level per clock. There is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `pwm_evt_router`

## Requirements
- R1: After reset, the control word reads 0x0000, the update request is low and the postscaler count is zero.
- R2: A control write stores bits 15:11 (postscaler code), 10:8 (enables for C, B, A in that order, bit 8 = A) and 4:0. Bits 7:5 always read back as zero. The stored word appears on the read port the cycle after the write.
- R3: An ADC event occurs in a clock when at least one compare pulse has its enable bit set. Several enabled pulses in the same clock count as one event.
- R4: With postscaler code N, the ADC trigger pulses for one clock, in the same cycle as the event, on the (N+1)-th event counted since the last trigger or control write. Code 0 passes every event and code 31 passes every 32nd.
- R5: Any control write returns the postscaler count to zero. An event in the write cycle is neither counted nor triggered.
- R6: When all three enables are zero, the ADC trigger stays low and the count keeps its value.
- R7: The generator trigger output follows, in the same cycle, end-of-cycle for select code 0 (bits 2:0), compare A for 1, compare B for 2 and compare C for 3. For codes 4 to 7 it is held low.
- R8: Update mode (bits 4:3) selects what sets the request in addition to the software strobe. Mode 0 adds nothing, mode 1 adds the duty-write strobe, mode 2 the phase-write strobe and mode 3 the compare-A-write strobe. Unselected strobes are ignored.
- R9: The update request rises the cycle after a setting strobe and stays high until a clear pulse. If a set and a clear occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 16 | Control word write data |
| reg_rd_data | output | 16 | Control word read data |
| cmp_a | input | 1 | Compare A match pulse |
| cmp_b | input | 1 | Compare B match pulse |
| cmp_c | input | 1 | Compare C match pulse |
| eoc | input | 1 | End-of-cycle pulse |
| sw_update | input | 1 | Software update request strobe |
| wr_duty | input | 1 | Duty register write strobe |
| wr_phase | input | 1 | Phase register write strobe |
| wr_cmpa | input | 1 | Compare-A register write strobe |
| upd_clear | input | 1 | Update taken; clears the request |
| adc_trig | output | 1 | Postscaled ADC trigger pulse |
| gen_trig | output | 1 | Selected generator trigger |
| upd_req | output | 1 | Sticky update request flag |

## Verification
The hardest case to reach from the ports is the wrap of a large postscaler code. This matters most when several enabled compares coincide, because then the event count and the pulse count differ. The stimulus sweeps every postscaler code against every enable mask. Each run uses an event pattern that mixes single, coincident and disabled-only compare pulses for more than 32 cycles. The bench tracks its own event counter and predicts each trigger cycle. Control writes in the middle of a run check the counter restart.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int CTRL_W   = 16;
  localparam int PS_W     = 5;
  localparam int NUM_CMP  = 3;
  localparam int PS_LSB   = 11;
  localparam int EN_LSB   = 8;
  localparam int UPD_LSB  = 3;
  localparam int UPD_W    = 2;
  localparam int SEL_LSB  = 0;
  localparam int SEL_W    = 3;

  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hFF1F;

  typedef enum logic [SEL_W-1:0] {
    GSEL_EOC  = 3'd0,
    GSEL_CMPA = 3'd1,
    GSEL_CMPB = 3'd2,
    GSEL_CMPC = 3'd3
  } gen_sel_e;

  typedef enum logic [UPD_W-1:0] {
    UMODE_SW    = 2'd0,
    UMODE_DUTY  = 2'd1,
    UMODE_PHASE = 2'd2,
    UMODE_CMPA  = 2'd3
  } upd_mode_e;
endpackage

// File: rtl/evt_ctrl_reg.sv
module evt_ctrl_reg
  import pwm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl <= '0;
    else if (wr_en) ctrl <= wr_data & CTRL_MASK;
  end
endmodule

// File: rtl/evt_postscaler.sv
module evt_postscaler #(
  parameter int PS_W    = 5,
  parameter int NUM_CMP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] cmp,
  input  logic [NUM_CMP-1:0] en,
  input  logic [PS_W-1:0]    ps_code,
  input  logic               restart,
  output logic               trig
);
  logic [NUM_CMP-1:0] hit;
  logic [PS_W-1:0]    cnt;
  logic               ev;
  logic               at_limit;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_gate
    assign hit[g] = cmp[g] & en[g];
  end

  assign ev       = |hit;
  assign at_limit = (cnt == ps_code);
  assign trig     = ev && at_limit && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (ev)      cnt <= at_limit ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/evt_gen_select.sv
module evt_gen_select
  import pwm_evt_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             eoc,
  input  logic             cmp_a,
  input  logic             cmp_b,
  input  logic             cmp_c,
  output logic             gen_trig
);
  always_comb begin
    case (sel)
      GSEL_EOC:  gen_trig = eoc;
      GSEL_CMPA: gen_trig = cmp_a;
      GSEL_CMPB: gen_trig = cmp_b;
      GSEL_CMPC: gen_trig = cmp_c;
      default:   gen_trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/evt_update_req.sv
module evt_update_req
  import pwm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [UPD_W-1:0] mode,
  input  logic             sw_update,
  input  logic             wr_duty,
  input  logic             wr_phase,
  input  logic             wr_cmpa,
  input  logic             clear,
  output logic             req
);
  logic auto_set;
  logic set;

  always_comb begin
    case (mode)
      UMODE_DUTY:  auto_set = wr_duty;
      UMODE_PHASE: auto_set = wr_phase;
      UMODE_CMPA:  auto_set = wr_cmpa;
      default:     auto_set = 1'b0;
    endcase
  end

  assign set = sw_update | auto_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= set | (req & ~clear);
  end
endmodule

// File: rtl/pwm_evt_router.sv
module pwm_evt_router
  import pwm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [CTRL_W-1:0] reg_wr_data,
  output logic [CTRL_W-1:0] reg_rd_data,
  input  logic              cmp_a,
  input  logic              cmp_b,
  input  logic              cmp_c,
  input  logic              eoc,
  input  logic              sw_update,
  input  logic              wr_duty,
  input  logic              wr_phase,
  input  logic              wr_cmpa,
  input  logic              upd_clear,
  output logic              adc_trig,
  output logic              gen_trig,
  output logic              upd_req
);
  logic [CTRL_W-1:0] ctrl;

  evt_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .ctrl    (ctrl)
  );

  assign reg_rd_data = ctrl;

  evt_postscaler #(.PS_W(PS_W), .NUM_CMP(NUM_CMP)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp     ({cmp_c, cmp_b, cmp_a}),
    .en      (ctrl[EN_LSB +: NUM_CMP]),
    .ps_code (ctrl[PS_LSB +: PS_W]),
    .restart (reg_wr_en),
    .trig    (adc_trig)
  );

  evt_gen_select u_sel (
    .sel      (ctrl[SEL_LSB +: SEL_W]),
    .eoc      (eoc),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .cmp_c    (cmp_c),
    .gen_trig (gen_trig)
  );

  evt_update_req u_upd (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (ctrl[UPD_LSB +: UPD_W]),
    .sw_update (sw_update),
    .wr_duty   (wr_duty),
    .wr_phase  (wr_phase),
    .wr_cmpa   (wr_cmpa),
    .clear     (upd_clear),
    .req       (upd_req)
  );
endmodule

// File: rtl/pwm_evt_router_chk.sv
module pwm_evt_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [15:0] reg_wr_data,
  input logic [15:0] reg_rd_data,
  input logic        cmp_a,
  input logic        cmp_b,
  input logic        cmp_c,
  input logic        eoc,
  input logic        sw_update,
  input logic        wr_duty,
  input logic        wr_phase,
  input logic        wr_cmpa,
  input logic        upd_clear,
  input logic        adc_trig,
  input logic        gen_trig,
  input logic        upd_req
);
  logic any_en_hit;
  assign any_en_hit = |(reg_rd_data[10:8] & {cmp_c, cmp_b, cmp_a});

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rd_data == ($past(reg_wr_data) & 16'hFF1F));

  // R3
  trig_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> any_en_hit);

  // R4
  div1_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[15:11] == 5'd0 && any_en_hit && !reg_wr_en) |-> adc_trig);

  // R6
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[10:8] == 3'b000) |-> !adc_trig);

  // R7
  reserved_sel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[2] |-> !gen_trig);

  // R9
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_update |=> upd_req);

  // R9
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_clear && !sw_update && !wr_duty && !wr_phase && !wr_cmpa) |=> !upd_req);
endmodule

bind pwm_evt_router pwm_evt_router_chk u_chk (.*);

// File: tb/pwm_evt_router_test.sv
module pwm_evt_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic        cmp_a = 0, cmp_b = 0, cmp_c = 0, eoc = 0;
  logic        sw_update = 0, wr_duty = 0, wr_phase = 0, wr_cmpa = 0, upd_clear = 0;
  logic        adc_trig, gen_trig, upd_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pwm_evt_router uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [15:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(reg_rd_data == 16'h0 && !upd_req && !adc_trig, "R1", reg_rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 readback and reserved bits 7:5
    wr_ctrl(16'hFFFF);
    chk(reg_rd_data == 16'hFF1F, "R2", reg_rd_data, 16'hFF1F);
    wr_ctrl(16'h00E0);
    chk(reg_rd_data == 16'h0000, "R2", reg_rd_data, 0);

    // R3 R4 R6 postscaler sweep
    for (int ps = 0; ps < 32; ps++) begin
      for (int en = 0; en < 8; en++) begin
        int cnt = 0;
        wr_ctrl(16'((ps << 11) | (en << 8)));
        for (int i = 0; i < 70; i++) begin
          logic [2:0] pat = 3'((i * 5 + (i >> 2)) % 8);
          bit ev;
          bit exp_t;
          if (i == 50) begin
            // R5 mid-run write restarts count; event in write cycle ignored
            {cmp_c, cmp_b, cmp_a} = 3'b111;
            reg_wr_en = 1'b1; reg_wr_data = 16'((ps << 11) | (en << 8));
            #1;
            chk(adc_trig == 1'b0, "R5", adc_trig, 0);
            cnt = 0;
            @(negedge clk);
            reg_wr_en = 1'b0;
            continue;
          end
          {cmp_c, cmp_b, cmp_a} = pat;
          ev = |(pat & 3'(en));
          exp_t = ev && (cnt == ps);
          #1;
          if (en == 0) chk(adc_trig == 1'b0, "R6", adc_trig, 0);
          else if ($countones(pat & 3'(en)) > 1) chk(adc_trig == exp_t, "R3", adc_trig, exp_t);
          else chk(adc_trig == exp_t, "R4", adc_trig, exp_t);
          if (ev) cnt = (cnt == ps) ? 0 : cnt + 1;
          @(negedge clk);
        end
        {cmp_c, cmp_b, cmp_a} = 3'b000;
      end
    end

    // R7 generator select sweep
    for (int sel = 0; sel < 8; sel++) begin
      wr_ctrl(16'(sel));
      for (int p = 0; p < 16; p++) begin
        logic [3:0] v = 4'(p);
        logic exp_g;
        {eoc, cmp_c, cmp_b, cmp_a} = v;
        case (sel)
          0: exp_g = v[3];
          1: exp_g = v[0];
          2: exp_g = v[1];
          3: exp_g = v[2];
          default: exp_g = 1'b0;
        endcase
        #1;
        chk(gen_trig == exp_g, "R7", gen_trig, exp_g);
        @(negedge clk);
      end
    end
    {eoc, cmp_c, cmp_b, cmp_a} = 4'b0;

    // R8 R9 update request sweep
    for (int m = 0; m < 4; m++) begin
      wr_ctrl(16'(m << 3));
      for (int s = 0; s < 16; s++) begin
        logic [3:0] v = 4'(s);
        bit exp_u;
        exp_u = v[0] || (m == 1 && v[1]) || (m == 2 && v[2]) || (m == 3 && v[3]);
        {wr_cmpa, wr_phase, wr_duty, sw_update} = v;
        @(negedge clk);
        {wr_cmpa, wr_phase, wr_duty, sw_update} = 4'b0;
        chk(upd_req == exp_u, "R8", upd_req, exp_u);
        @(negedge clk);
        chk(upd_req == exp_u, "R9", upd_req, exp_u);
        upd_clear = 1'b1;
        @(negedge clk);
        upd_clear = 1'b0;
        chk(upd_req == 1'b0, "R9", upd_req, 0);
      end
    end
    // R9 set wins over clear
    sw_update = 1'b1; upd_clear = 1'b1;
    @(negedge clk);
    sw_update = 1'b0; upd_clear = 1'b0;
    chk(upd_req == 1'b1, "R9", upd_req, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule